// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers single-cycle event strobes from a receiver baseband that runs two configurations, A and B. Each configuration reports wake-up, frame-sync, message-ID and end-of-message events. There is also one power-on-reset indicator. Every qualified event is latched into a nine-bit status word. The status word is combined with a mask to drive one interrupt pin, and the polarity of that pin can be programmed.

Status flags follow a precedence chain. A wake-up discards the frame-sync flags of both configurations and the wake-up flag of the other configuration. A frame-sync discards the message-ID and end-of-message flags of both configurations and the frame-sync flag of the other configuration.

After a reset every status flag reads as one and the interrupt level is held low. The first event after reset wipes the word and raises the interrupt, even when that event is masked. A status read through the serial register interface clears the whole word.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `stat_word` becomes 9'h1FF. The internal interrupt level becomes 0, and `irq_pin` is driven with the fixed default active-low polarity, so it reads 1 whatever the value of `irq_pol_high`. The programmed polarity takes over from the first edge at which reset is high.
- R2: Take the first edge after reset at which any qualified event is present. At that edge the status word becomes exactly the set of those events. The interrupt level becomes 1 and stays 1 until a status read, even if every one of those events is masked.
- R3: Outside the first-event case, each qualified event sets its status bit at the next edge. The interrupt level is 1 exactly when a status bit is set whose `irq_mask` bit is 1. Layout for both status and mask, from bit 8 down to bit 0: POR, wake A, wake B, fsync A, fsync B, msg-ID A, msg-ID B, EOM A, EOM B.
- R4: The POR indicator (bit 8) raises the interrupt level whatever the value of `irq_mask[8]`.
- R5: A wake-up event on one configuration clears bits 5 and 4 and the other configuration's wake-up bit (7 or 6).
- R6: A frame-sync event on one configuration clears bits 3..0 and the other configuration's frame-sync bit (5 or 4).
- R7: A `stat_rd` pulse clears all status bits at the next edge. The interrupt level then returns to 0.
- R8: When `stat_rd` and an event fall in the same cycle, the event's bit is set after the clear.
- R9: Wake-up events are taken in every receive mode. Frame-sync, message-ID and end-of-message strobes are taken only when `rx_mode` is 2'b01 or 2'b10. In modes 2'b00 and 2'b11 they leave the status word and the pin unchanged.
- R10: Out of reset, `irq_pin` equals the interrupt level when `irq_pol_high` is 1 and its inverse when `irq_pol_high` is 0. The pin follows a change of `irq_pol_high` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_mode | input | 2 | Receive mode select; 01 and 10 are the packet modes |
| evt_wake | input | 2 | Wake-up strobes, bit 0 = config A, bit 1 = config B |
| evt_fsync | input | 2 | Frame-sync strobes, bit 0 = A, bit 1 = B |
| evt_msgid | input | 2 | Message-ID strobes, bit 0 = A, bit 1 = B |
| evt_eom | input | 2 | End-of-message strobes, bit 0 = A, bit 1 = B |
| evt_por | input | 1 | Power-on-reset indicator strobe |
| irq_mask | input | 9 | Interrupt enable per status bit (same layout as status) |
| irq_pol_high | input | 1 | 1 = active-high pin, 0 = active-low pin |
| stat_rd | input | 1 | Status read strobe from the register interface |
| stat_word | output | 9 | Latched status word |
| irq_pin | output | 1 | Interrupt pin level |

## Verification
A status read can land in the same cycle as a new event. A clearing event can also land in the same cycle as the event it would clear. The bench provokes both cases by raising `stat_rd` together with an end-of-message strobe, and by raising wake-up and frame-sync strobes on the same edge. A behavioural reference model judges each clock's status word and pin. The first event after reset is provoked while fully masked. It must raise the pin anyway, and a later read must drop it.

// File: rtl/irq_status_pkg.sv
// Package: shared constants, status bit layout and helper functions for the
// interrupt status controller. Assumes exactly two receive configurations.
package irq_status_pkg;
    localparam int NUM_CFG = 2;
    localparam int NUM_SRC = 9;

    // Bit positions of configuration A; configuration B sits one bit lower.
    localparam int BIT_POR   = 8;
    localparam int BIT_WAKE  = 7;
    localparam int BIT_FSYNC = 5;
    localparam int BIT_MSGID = 3;
    localparam int BIT_EOM   = 1;

    typedef logic [NUM_SRC-1:0] irq_vec_t;

    function automatic int wake_bit(input int cfg);
        return BIT_WAKE - cfg;
    endfunction

    function automatic int fsync_bit(input int cfg);
        return BIT_FSYNC - cfg;
    endfunction

    function automatic int msgid_bit(input int cfg);
        return BIT_MSGID - cfg;
    endfunction

    function automatic int eom_bit(input int cfg);
        return BIT_EOM - cfg;
    endfunction

    // Flags erased by the events of one configuration (precedence chain).
    function automatic irq_vec_t clear_set(input irq_vec_t evt, input int cfg);
        irq_vec_t res;
        int other;
        res   = '0;
        other = NUM_CFG - 1 - cfg;
        if (evt[wake_bit(cfg)]) begin
            res[fsync_bit(0)]   = 1'b1;
            res[fsync_bit(1)]   = 1'b1;
            res[wake_bit(other)] = 1'b1;
        end
        if (evt[fsync_bit(cfg)]) begin
            res[msgid_bit(0)]     = 1'b1;
            res[msgid_bit(1)]     = 1'b1;
            res[eom_bit(0)]       = 1'b1;
            res[eom_bit(1)]       = 1'b1;
            res[fsync_bit(other)] = 1'b1;
        end
        return res;
    endfunction
endpackage

// File: rtl/irq_evt_qualify.sv
// Module: packs the event strobes into the status layout and drops the
// packet-only events when the receive mode is not a packet mode.
// Assumes strobes are synchronous to clk and one cycle wide.
module irq_evt_qualify
    import irq_status_pkg::*;
#(
    parameter int                MODE_W     = 2,
    parameter logic [MODE_W-1:0] PKT_MODE_0 = 1,
    parameter logic [MODE_W-1:0] PKT_MODE_1 = 2
) (
    input  logic [MODE_W-1:0]  rx_mode,
    input  logic [NUM_CFG-1:0] wake,
    input  logic [NUM_CFG-1:0] fsync,
    input  logic [NUM_CFG-1:0] msgid,
    input  logic [NUM_CFG-1:0] eom,
    input  logic               por,
    output irq_vec_t           evt
);
    logic pkt_mode;

    // Decide whether packet-only events are honoured.
    always_comb pkt_mode = (rx_mode == PKT_MODE_0) || (rx_mode == PKT_MODE_1);

    // Map every strobe onto its status bit position.
    always_comb begin
        evt          = '0;
        evt[BIT_POR] = por;
        for (int c = 0; c < NUM_CFG; c++) begin
            evt[wake_bit(c)]  = wake[c];
            evt[fsync_bit(c)] = fsync[c] & pkt_mode;
            evt[msgid_bit(c)] = msgid[c] & pkt_mode;
            evt[eom_bit(c)]   = eom[c]   & pkt_mode;
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
// Module: holds the status word, the "first event pending" flag and the
// sticky forced-interrupt flag. Applies the clear chain and read clearing.
// Assumes evt is already qualified by receive mode.
module irq_status_reg
    import irq_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t evt,
    input  logic     stat_rd,
    output irq_vec_t status,
    output logic     first_pend,
    output logic     forced
);
    logic [NUM_CFG-1:0][NUM_SRC-1:0] clr_cfg;
    irq_vec_t clr_all;
    irq_vec_t status_nx;
    logic     any_evt;

    // One clear vector per configuration.
    for (genvar c = 0; c < NUM_CFG; c++) begin : g_clr
        assign clr_cfg[c] = clear_set(evt, c);
    end

    // Merge per-configuration clears and form the next status word.
    always_comb begin
        clr_all = '0;
        for (int c = 0; c < NUM_CFG; c++) clr_all |= clr_cfg[c];
        any_evt = |evt;
        if (first_pend && any_evt)
            status_nx = evt;
        else
            status_nx = ((stat_rd ? '0 : status) & ~clr_all) | evt;
    end

    // Status, first-event and forced-level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status     <= '1;
            first_pend <= 1'b1;
            forced     <= 1'b0;
        end else begin
            status <= status_nx;
            if (first_pend && any_evt) begin
                first_pend <= 1'b0;
                forced     <= 1'b1;
            end else if (stat_rd) begin
                forced <= 1'b0;
            end
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt))); // R3
    AST_WAKE_CLEARS_FSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[BIT_WAKE] && !evt[BIT_FSYNC] && !evt[BIT_FSYNC-1] && !evt[BIT_WAKE-1])
        |=> (!status[BIT_FSYNC] && !status[BIT_FSYNC-1] && !status[BIT_WAKE-1])); // R5
    AST_FSYNC_CLEARS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[BIT_FSYNC-1] && (evt[3:0] == 4'b0) && !evt[BIT_FSYNC])
        |=> ((status[3:0] == 4'b0) && !status[BIT_FSYNC])); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (evt == '0)) |=> (status == '0)); // R7
endmodule

// File: rtl/irq_pin_drive.sv
// Module: forms the interrupt level from status, mask and the first-event
// flags, and drives the pin with the default polarity while in reset and
// the programmed polarity afterwards. POR bit is never masked.
module irq_pin_drive
    import irq_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t status,
    input  logic     first_pend,
    input  logic     forced,
    input  irq_vec_t irq_mask,
    input  logic     pol_high,
    output logic     irq_pin
);
    irq_vec_t en_mask;
    logic     irq_lvl;
    logic     in_rst_q;

    // Track whether the default reset polarity applies.
    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
    end

    // Level: held low until the first event, then forced or enabled status.
    always_comb begin
        en_mask          = irq_mask;
        en_mask[BIT_POR] = 1'b1;
        irq_lvl = !first_pend && (forced || (|(status & en_mask)));
    end

    // Pin polarity selection.
    always_comb irq_pin = in_rst_q ? !irq_lvl : (pol_high ? irq_lvl : !irq_lvl);

    AST_FIRST_EVENT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(first_pend) |-> irq_lvl); // R2
    AST_POR_UNMASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_pend && status[BIT_POR]) |-> irq_lvl); // R4
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top of the masked interrupt status controller. Qualifies events,
// keeps the status word and drives the interrupt pin.
// Assumes all inputs synchronous to clk; rst_n synchronous active-low.
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] rx_mode,
    input  logic [1:0]        evt_wake,
    input  logic [1:0]        evt_fsync,
    input  logic [1:0]        evt_msgid,
    input  logic [1:0]        evt_eom,
    input  logic              evt_por,
    input  logic [8:0]        irq_mask,
    input  logic              irq_pol_high,
    input  logic              stat_rd,
    output logic [8:0]        stat_word,
    output logic              irq_pin
);
    irq_vec_t evt_q;
    irq_vec_t status;
    logic     first_pend;
    logic     forced;

    irq_evt_qualify #(
        .MODE_W     (MODE_W),
        .PKT_MODE_0 (MODE_W'(1)),
        .PKT_MODE_1 (MODE_W'(2))
    ) i_qualify (
        .rx_mode (rx_mode),
        .wake    (evt_wake),
        .fsync   (evt_fsync),
        .msgid   (evt_msgid),
        .eom     (evt_eom),
        .por     (evt_por),
        .evt     (evt_q)
    );

    irq_status_reg i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_q),
        .stat_rd    (stat_rd),
        .status     (status),
        .first_pend (first_pend),
        .forced     (forced)
    );

    irq_pin_drive i_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .status     (status),
        .first_pend (first_pend),
        .forced     (forced),
        .irq_mask   (irq_mask),
        .pol_high   (irq_pol_high),
        .irq_pin    (irq_pin)
    );

    // Expose the status word.
    always_comb stat_word = status;

    AST_MODE_GATES_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_mode == 2'b00 || rx_mode == 2'b11) && !first_pend && !stat_rd &&
         (evt_wake == 2'b0)) |=> ($past(status[5:0]) == status[5:0]) || $past(evt_por)); // R9
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_mode = 2'b01;
    logic [1:0] evt_wake = '0, evt_fsync = '0, evt_msgid = '0, evt_eom = '0;
    logic       evt_por = 1'b0;
    logic [8:0] irq_mask = '0;
    logic       irq_pol_high = 1'b1;
    logic       stat_rd = 1'b0;
    logic [8:0] stat_word;
    logic       irq_pin;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done = 0;

    // Reference model state
    int m_status;
    bit m_first, m_forced, m_inrst;

    always #4 clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .evt_wake(evt_wake),
        .evt_fsync(evt_fsync), .evt_msgid(evt_msgid), .evt_eom(evt_eom),
        .evt_por(evt_por), .irq_mask(irq_mask), .irq_pol_high(irq_pol_high),
        .stat_rd(stat_rd), .stat_word(stat_word), .irq_pin(irq_pin)
    );

    function automatic int model_events();
        int e = 0;
        bit pkt = (rx_mode == 2'b01) || (rx_mode == 2'b10);
        if (evt_por) e |= 256;
        for (int c = 0; c < 2; c++) begin
            if (evt_wake[c]) e |= (1 << (7 - c));
            if (pkt && evt_fsync[c]) e |= (1 << (5 - c));
            if (pkt && evt_msgid[c]) e |= (1 << (3 - c));
            if (pkt && evt_eom[c]) e |= (1 << (1 - c));
        end
        return e;
    endfunction

    task automatic model_step();
        int e, clr;
        if (!rst_n) begin
            m_status = 'h1FF; m_first = 1; m_forced = 0; m_inrst = 1;
            return;
        end
        m_inrst = 0;
        e = model_events();
        if (m_first && e != 0) begin
            m_status = e; m_first = 0; m_forced = 1;
            return;
        end
        clr = 0;
        if (e & 'h080) clr |= 'h030 | 'h040;
        if (e & 'h040) clr |= 'h030 | 'h080;
        if (e & 'h020) clr |= 'h00F | 'h010;
        if (e & 'h010) clr |= 'h00F | 'h020;
        m_status = ((stat_rd ? 0 : m_status) & ~clr) | e;
        if (stat_rd) m_forced = 0;
    endtask

    function automatic bit model_pin();
        bit lvl = !m_first && (m_forced || ((m_status & (int'(irq_mask) | 256)) != 0));
        if (m_inrst) return !lvl;
        return irq_pol_high ? lvl : !lvl;
    endfunction

    task automatic compare();
        n_tests++;
        if (int'(stat_word) != m_status) begin
            n_fail++;
            $display("FAIL %s status actual=%03h expected=%03h", cur_req, stat_word, m_status[8:0]);
        end
        n_tests++;
        if (irq_pin !== model_pin()) begin
            n_fail++;
            $display("FAIL %s irq_pin actual=%b expected=%b", cur_req, irq_pin, model_pin());
        end
    endtask

    // One clock: model updates at the edge, outputs compared 2 ns later,
    // strobes dropped at the following falling edge.
    task automatic tick();
        @(posedge clk);
        model_step();
        #2;
        compare();
        @(negedge clk);
        evt_wake = '0; evt_fsync = '0; evt_msgid = '0; evt_eom = '0;
        evt_por = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset with active-high programmed, pin must show default inactive
        cur_req = "R1"; rst_n = 0; irq_pol_high = 1; irq_mask = '0;
        idle(3);
        // R2: first event masked still raises interrupt, clears the word
        cur_req = "R2"; rst_n = 1; idle(2);
        evt_msgid = 2'b01; tick(); idle(2);
        cur_req = "R7"; stat_rd = 1; tick(); idle(1);
        // R3: enabled vs masked events
        cur_req = "R3"; irq_mask = 9'h080;
        evt_wake = 2'b10; tick(); idle(1);
        evt_eom = 2'b10; tick();
        evt_wake = 2'b01; tick(); idle(1);
        cur_req = "R7"; stat_rd = 1; tick();
        // R4: POR with mask all zero
        cur_req = "R4"; irq_mask = '0; evt_por = 1; tick(); idle(1);
        cur_req = "R7"; stat_rd = 1; tick();
        // R5: wake clears fsync flags and the other wake flag
        cur_req = "R5"; irq_mask = 9'h1FF;
        evt_fsync = 2'b11; tick(); evt_wake = 2'b10; tick();
        evt_wake = 2'b01; tick(); idle(1);
        evt_fsync = 2'b01; tick(); evt_wake = 2'b10; evt_fsync = 2'b10; tick();
        // R6: fsync clears msg-id / eom and the other fsync
        cur_req = "R6";
        evt_msgid = 2'b11; evt_eom = 2'b11; tick();
        evt_fsync = 2'b10; tick(); evt_msgid = 2'b01; evt_eom = 2'b10; tick();
        evt_fsync = 2'b01; tick(); idle(1);
        // R8: read and event in the same cycle
        cur_req = "R8"; stat_rd = 1; evt_eom = 2'b01; tick(); idle(1);
        stat_rd = 1; evt_wake = 2'b01; evt_fsync = 2'b10; tick();
        cur_req = "R7"; stat_rd = 1; tick(); idle(1);
        // R9: non-packet modes drop packet events, keep wake
        cur_req = "R9"; rx_mode = 2'b00;
        evt_fsync = 2'b11; evt_msgid = 2'b11; evt_eom = 2'b11; tick(); idle(1);
        evt_wake = 2'b10; evt_eom = 2'b01; tick();
        rx_mode = 2'b11; evt_fsync = 2'b01; evt_msgid = 2'b10; tick();
        rx_mode = 2'b10; evt_msgid = 2'b10; tick(); idle(1);
        // R10: polarity flip without clock delay
        cur_req = "R10"; irq_pol_high = 0; #1; compare(); idle(1);
        stat_rd = 1; tick(); idle(1);
        irq_pol_high = 1; #1; compare(); idle(1);
        // R1 / R2 again: reset mid-run with active-low programmed
        cur_req = "R1"; irq_pol_high = 0; rst_n = 0; idle(2);
        cur_req = "R2"; rst_n = 1; irq_mask = '0; idle(1);
        evt_wake = 2'b01; evt_fsync = 2'b01; rx_mode = 2'b01; tick(); idle(2);
        cur_req = "R3"; evt_eom = 2'b01; tick(); idle(1);
        cur_req = "R7"; stat_rd = 1; tick(); idle(2);
        done = 1;
    end

    initial begin
        for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule